// File: doc/BRIEF.md
# Per-Rank Activate Rate Limiter

This block decides, one request per clock, whether a row activate command may go to a given rank. The scheduler presents an activate request together with a rank index. The block answers in the same cycle with a grant. The decision rests only on the request and on timing history that the block keeps separately for each rank.

Two programmable limits, both counted in controller clocks, constrain the activates to one rank. The first is a minimum spacing between consecutive activates. The second is a rolling window that may hold no more than four activates. Each rank holds a four-slot history of its most recent activates. Each slot counts down the window that its activate still occupies. A grant reuses the slot that was filled longest ago and restarts that rank's spacing counter. A limit field of zero lifts that limit completely. Bank state, row state, precharge, refresh and column commands belong to other logic.

Top module: `act_rate_limiter`

## Requirements
- R1: After reset, every rank has empty history and an idle spacing counter, so the first request to any rank is granted in its own cycle.
- R2: Let G be the 3-bit `cfg_act_gap` value. After a grant to rank r in cycle t, a later request to rank r is refused in cycles t+1 to t+G-1 and is granted from cycle t+G on, provided the window rule also allows it. G = 0 and G = 1 impose no spacing.
- R3: Let W be the 6-bit `cfg_act_window` value. A rank receives at most four grants in any W consecutive cycles. A request in cycle t to a rank that already has four earlier grants is granted only if the fourth-most-recent of those grants happened in cycle t-W or earlier.
- R4: Grants to one rank leave the spacing counter and the window history of every other rank unchanged. A request to another rank is decided only on that rank's own history.
- R5: `act_grant` is a combinational function of `act_req`, `act_req_rank` and the stored state, valid in the same cycle. It is never high while `act_req` is low. A request that meets both rules is always granted.
- R6: With both limit fields at zero, every request is granted, including requests to the same rank on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_act_gap | input | GAP_W (3) | Minimum clocks between activates to one rank; 0 or 1 means none |
| cfg_act_window | input | WIN_W (6) | Rolling window length in clocks for the four-activate cap; 0 means none |
| act_req | input | 1 | Activate request valid |
| act_req_rank | input | RANK_W (2) | Rank targeted by the request |
| act_grant | output | 1 | Activate may issue this cycle |

## Verification
A spacing counter that is stuck or loaded one too high shows up on the second activate to a rank. That activate is refused or let through a single cycle away from the expected cycle, so the error appears within G clocks of a grant. A history slot that is not replaced, or that is replaced out of order, shows up only on the fifth activate within a window. That needs at least four grants before it, so the error appears up to W clocks later, and the bench drives ranks to full history on purpose. State that leaks between ranks appears as a refused request to an idle rank in the same cycle as the unrelated grant.

// File: rtl/act_lim_pkg.sv
package act_lim_pkg;
   // Number of remembered activates per rank (the rolling-window cap)
   localparam int HIST_DEPTH = 4;

   // Counter load for a limit of `lim` clocks: the next permitted cycle is
   // lim clocks after the grant, so the counter starts at lim-1.
   function automatic int unsigned limit_load(input int unsigned lim);
      return (lim == 0) ? 0 : lim - 1;
   endfunction
endpackage

// File: rtl/rank_gap_timer.sv
module rank_gap_timer #(
   parameter int GAP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [GAP_W-1:0] cfg_gap,
   output logic             ready
);
   import act_lim_pkg::*;

   logic [GAP_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load) begin
         remain_q <= GAP_W'(limit_load(int'(cfg_gap)));
      end else if (remain_q != '0) begin
         remain_q <= remain_q - 1'b1;
      end
   end

   assign ready = (remain_q == '0);
endmodule

// File: rtl/rank_faw_window.sv
module rank_faw_window #(
   parameter int WIN_W = 6,
   parameter int DEPTH = act_lim_pkg::HIST_DEPTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIN_W-1:0] cfg_win,
   output logic             ready
);
   import act_lim_pkg::*;

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [WIN_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0] oldest_q;
   logic [DEPTH-1:0] slot_idle;

   // Each slot counts down the window its activate still occupies
   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[s] <= '0;
         end else if (load && (oldest_q == PTR_W'(s))) begin
            slot_q[s] <= WIN_W'(limit_load(int'(cfg_win)));
         end else if (slot_q[s] != '0) begin
            slot_q[s] <= slot_q[s] - 1'b1;
         end
      end
      assign slot_idle[s] = (slot_q[s] == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oldest_q <= '0;
      end else if (load) begin
         oldest_q <= (oldest_q == PTR_W'(DEPTH - 1)) ? '0 : oldest_q + 1'b1;
      end
   end

   // Room for another activate once the oldest slot has left the window
   assign ready = slot_idle[oldest_q];
endmodule

// File: rtl/act_rate_limiter.sv
module act_rate_limiter #(
   parameter  int NUM_RANKS = 4,
   parameter  int GAP_W     = 3,
   parameter  int WIN_W     = 6,
   localparam int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GAP_W-1:0]  cfg_act_gap,
   input  logic [WIN_W-1:0]  cfg_act_window,
   input  logic              act_req,
   input  logic [RANK_W-1:0] act_req_rank,
   output logic              act_grant
);
   initial begin
      assert (NUM_RANKS >= 1) else $error("NUM_RANKS must be at least 1");
      assert (GAP_W >= 1 && GAP_W <= 16) else $error("GAP_W out of range");
      assert (WIN_W >= 1 && WIN_W <= 16) else $error("WIN_W out of range");
   end

   logic [NUM_RANKS-1:0] rank_sel;
   logic [NUM_RANKS-1:0] gap_ready;
   logic [NUM_RANKS-1:0] win_ready;
   logic [NUM_RANKS-1:0] rank_issue;

   for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
      assign rank_sel[r]   = act_req && (act_req_rank == RANK_W'(r));
      assign rank_issue[r] = rank_sel[r] && gap_ready[r] && win_ready[r];

      rank_gap_timer #(.GAP_W(GAP_W)) gap_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (rank_issue[r]),
         .cfg_gap (cfg_act_gap),
         .ready   (gap_ready[r])
      );

      rank_faw_window #(.WIN_W(WIN_W)) win_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (rank_issue[r]),
         .cfg_win (cfg_act_window),
         .ready   (win_ready[r])
      );
   end

   assign act_grant = |rank_issue;
endmodule

// File: rtl/act_rate_limiter_chk.sv
module act_rate_limiter_chk #(
   parameter int NUM_RANKS = 4,
   parameter int GAP_W     = 3,
   parameter int WIN_W     = 6,
   parameter int RANK_W    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [GAP_W-1:0]  cfg_act_gap,
   input logic [WIN_W-1:0]  cfg_act_window,
   input logic              act_req,
   input logic [RANK_W-1:0] act_req_rank,
   input logic              act_grant
);
   localparam int AW = 17;
   localparam logic [AW-1:0] AGE_MAX = '1;

   // Clocks since each rank's last grant and since each of its last four grants
   logic [AW-1:0] since_q [NUM_RANKS];
   logic [AW-1:0] age_q   [NUM_RANKS][4];
   logic [1:0]    optr_q  [NUM_RANKS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NUM_RANKS; r++) begin
            since_q[r] <= AGE_MAX;
            optr_q[r]  <= '0;
            for (int k = 0; k < 4; k++) age_q[r][k] <= AGE_MAX;
         end
      end else begin
         for (int r = 0; r < NUM_RANKS; r++) begin
            if (since_q[r] != AGE_MAX) since_q[r] <= since_q[r] + 1'b1;
            for (int k = 0; k < 4; k++)
               if (age_q[r][k] != AGE_MAX) age_q[r][k] <= age_q[r][k] + 1'b1;
            if (act_grant && (act_req_rank == RANK_W'(r))) begin
               since_q[r]            <= AW'(1);
               age_q[r][optr_q[r]]   <= AW'(1);
               optr_q[r]             <= optr_q[r] + 1'b1;
            end
         end
      end
   end

   logic [AW-1:0] sel_since, sel_oldest;
   logic          spacing_met, window_met;

   always_comb begin
      sel_since  = since_q[act_req_rank];
      sel_oldest = age_q[act_req_rank][optr_q[act_req_rank]];
   end
   assign spacing_met = sel_since  >= AW'(cfg_act_gap);
   assign window_met  = sel_oldest >= AW'(cfg_act_window);

   p_grant_has_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      act_grant |-> act_req);

   p_gap_respected_r2: assert property (@(posedge clk) disable iff (!rst_n)
      act_grant |-> spacing_met);

   p_window_respected_r3: assert property (@(posedge clk) disable iff (!rst_n)
      act_grant |-> window_met);

   // Eligible requests are never held back by another rank's activity
   p_eligible_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (act_req && spacing_met && window_met) |-> act_grant);

   p_back_to_back_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (act_grant && cfg_act_gap >= GAP_W'(2)) |=>
         !(act_grant && act_req_rank == $past(act_req_rank)) || !$stable(cfg_act_gap));
endmodule

bind act_rate_limiter act_rate_limiter_chk #(
   .NUM_RANKS (NUM_RANKS),
   .GAP_W     (GAP_W),
   .WIN_W     (WIN_W),
   .RANK_W    (RANK_W)
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_act_gap    (cfg_act_gap),
   .cfg_act_window (cfg_act_window),
   .act_req        (act_req),
   .act_req_rank   (act_req_rank),
   .act_grant      (act_grant)
);

// File: tb/act_rate_limiter_tb.sv
`timescale 1ns/1ps
module act_rate_limiter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cfg_act_gap = '0;
   logic [5:0] cfg_act_window = '0;
   logic       act_req = 1'b0;
   logic [1:0] act_req_rank = '0;
   logic       act_grant;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;   // 250 MHz

   act_rate_limiter dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_act_gap    (cfg_act_gap),
      .cfg_act_window (cfg_act_window),
      .act_req        (act_req),
      .act_req_rank   (act_req_rank),
      .act_grant      (act_grant)
   );

   typedef struct packed {
      logic       req;
      logic [1:0] rank;
      logic       exp;
   } vec_t;

   // gap = 3, window = 15; one entry per clock, starting right after reset
   localparam int NV = 18;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 2'd0, 1'b1},   // 0  first to r0
      '{1'b1, 2'd0, 1'b0},   // 1  gap
      '{1'b1, 2'd0, 1'b0},   // 2  gap
      '{1'b1, 2'd0, 1'b1},   // 3  gap met
      '{1'b1, 2'd1, 1'b1},   // 4  other rank
      '{1'b1, 2'd1, 1'b0},   // 5  r1 gap
      '{1'b1, 2'd0, 1'b1},   // 6  r0 third
      '{1'b1, 2'd2, 1'b1},   // 7
      '{1'b0, 2'd0, 1'b0},   // 8  idle
      '{1'b1, 2'd0, 1'b1},   // 9  r0 fourth
      '{1'b1, 2'd1, 1'b1},   // 10
      '{1'b0, 2'd0, 1'b0},   // 11 idle
      '{1'b1, 2'd0, 1'b0},   // 12 window full
      '{1'b1, 2'd1, 1'b1},   // 13 r1 unaffected
      '{1'b1, 2'd0, 1'b0},   // 14 window full
      '{1'b1, 2'd0, 1'b1},   // 15 oldest left window
      '{1'b1, 2'd3, 1'b1},   // 16
      '{1'b1, 2'd0, 1'b0}    // 17 gap after 15
   };

   task automatic check(input logic got, input logic exp, input string tag);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: act_grant=%b expected %b", tag, got, exp);
      end
   endtask

   task automatic do_reset(input logic [2:0] gap, input logic [5:0] win);
      @(posedge clk); #1;
      rst_n = 1'b0; act_req = 1'b0;
      cfg_act_gap = gap; cfg_act_window = win;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   // Drive a request for one clock and check the same-cycle grant
   task automatic step(input logic req, input logic [1:0] rank, input logic exp,
                       input string tag);
      act_req = req; act_req_rank = rank;
      @(negedge clk);
      check(act_grant, exp, tag);
      @(posedge clk); #1;
   endtask

   initial begin
      // R1: reset state, no request
      do_reset(3'd3, 6'd15);
      @(negedge clk);
      check(act_grant, 1'b0, "R1 idle after reset");
      @(posedge clk); #1;

      // Table walk: R2 spacing, R3 window, R4 rank isolation
      for (int i = 0; i < NV; i++)
         step(TBL[i].req, TBL[i].rank, TBL[i].exp,
              $sformatf("R2 R3 R4 table step %0d", i));

      // R1: reset with r0 busy in both counters clears its history
      do_reset(3'd3, 6'd15);
      step(1'b1, 2'd0, 1'b1, "R1 grant right after reset");

      // R6: both fields zero, same rank every cycle
      do_reset(3'd0, 6'd0);
      for (int i = 0; i < 8; i++)
         step(1'b1, 2'd2, 1'b1, $sformatf("R6 back-to-back %0d", i));

      // R3 with gap 1 (no spacing) and window 5: four granted, fifth waits
      do_reset(3'd1, 6'd5);
      for (int i = 0; i < 11; i++)
         step(1'b1, 2'd3, (i == 4 || i == 9) ? 1'b0 : 1'b1,
              $sformatf("R3 window=5 cycle %0d", i));

      // R5: no request, no grant, even with an eligible rank
      step(1'b0, 2'd1, 1'b0, "R5 no grant without request");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule